// File: doc/BRIEF.md
# Tiled Texture Upload Address Generator

This block takes a 32-bit texture upload header and a stream of 16-bit texel words. It turns them into write commands for a square sheet of 16-bit texel locations, 2048 by 2048 at the default size. The header gives the placement, the dimensions, the texel depth and which levels are present. The incoming words carry the texture as 8x8 tiles. Within each tile the texels follow a fixed interleaved order, and the block undoes that order, so that every write lands at its true row and column.

After the base level, the block can place a chain of reduced levels. Each reduced level is half the size of the one before it and goes into a fixed corner region of the same 1024-row page. A start strobe latches the header. A single-cycle done pulse follows the last accepted write. The output is one registered write slot with a ready input. While that slot is stalled, the input side stops taking words, so no word is ever lost.

Top module: `tex_upload_addrgen`

## Requirements
- R1: After reset, `wrValid`, `done` and `inReady` are all low.
- R2: The base level starts at column 32*header[5:0] and at row 32*header[11:7], plus 1024 when header[20] is set. The write address is row*2048 + column, and both row and column wrap modulo 2048.
- R3: When header[23] is 1 (16-bit texels), each accepted word produces exactly one write. Its data is the word unchanged and its byte enable is 2'b11.
- R4: When header[23] is 0 (8-bit texels), each accepted word produces two writes: first from its high byte, then from its low byte. Each write puts the byte in both data lanes, with byte enable equal to header[22:21] (bit 0 is the low byte, bit 1 is the high byte).
- R5: The width is 32<<header[16:14] and the height is 32<<header[19:17]. Tiles of 8x8 are taken left to right, then top to bottom. Tile (tx,ty) of a level covers columns base+8*tx and rows base+8*ty onwards.
- R6: For 16-bit texels, the k-th word of a tile goes to the tile position d (d = row*8 + column) for which f(d XOR 1) = k, where f(i) = 16*(i[5:4]) + 2*i[3] + 4*(i[2:1]) + i[0].
- R7: For 8-bit texels, word w of a tile feeds the even column x and row y for which f(8*(y XOR 1) + (x XOR 1))/2 = w. The high byte goes to column x and the low byte to column x+1.
- R8: header[27:24] selects the levels: 0 = base then reduced levels, 1 = base only, 2 = reduced levels only. Any other value produces no write, holds `inReady` low, and gives a done pulse two cycles after start.
- R9: Reduced levels continue while both dimensions exceed 8, halving both each time. Level L (L >= 1) starts at column (2048 - 2048>>L) + X>>L and at row (1024 - 1024>>L) + Y>>L, plus 1024 on page 1, where X and Y are the base column and the unpaged base row.
- R10: While `wrValid` is high and `wrReady` is low, `wrAddr`, `wrData` and `wrBe` hold, and `inReady` is low.
- R11: `done` is high for exactly one cycle, the cycle after the last write handshake, and `wrValid` is low during it.
- R12: A start strobe during an upload is ignored, and the upload in progress continues under its own header.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Latch `header` and begin an upload when idle |
| header | input | 32 | Texture upload header |
| inValid | input | 1 | Texel word available |
| inReady | output | 1 | Texel word taken on this edge when both are high |
| inData | input | 16 | Texel word |
| wrValid | output | 1 | Write command present |
| wrReady | input | 1 | Write command taken on this edge when both are high |
| wrAddr | output | 22 | Texel address, row*2048 + column |
| wrData | output | 16 | Write data |
| wrBe | output | 2 | Byte enables, bit 1 high byte |
| done | output | 1 | One-cycle pulse after the final write |

## Verification
The bench builds the block with its default 11-bit sheet side. At that size the page offset of 1024 rows applies, and both the column and row wrap at 2047 are in play: a base column near 2016 with a 64-wide texture steps past the edge. Headers are kept to 32 and 64 texel dimensions, which still yields two or three reduced levels and reaches the smallest 8x8 level. Random stalls on both handshakes exercise the held-write path between the two bytes of an 8-bit word.

// File: rtl/texupl_pkg.sv
package texupl_pkg;
  localparam int TILE_LOG2  = 3;
  localparam int TILE_K_W   = 2 * TILE_LOG2;
  localparam int LVL_W      = 4;
  localparam int TILE_IDX_W = 10;
  localparam int TEXEL_W    = 16;

  localparam logic [3:0] KIND_FULL = 4'd0;
  localparam logic [3:0] KIND_BASE = 4'd1;
  localparam logic [3:0] KIND_MIPS = 4'd2;

  typedef struct packed {
    logic [5:0] xTile32;
    logic [4:0] yTile32;
    logic [2:0] wExp;
    logic [2:0] hExp;
    logic       page;
    logic [1:0] byteSel;
    logic       is16;
    logic [3:0] kind;
  } hdrFields_t;

  typedef struct packed {
    logic latchHdr;
    logic takeWord;
    logic emit;
    logic fromHold;
  } ctrlStrobe_t;

  typedef struct packed {
    logic [LVL_W-1:0]      level;
    logic [TILE_IDX_W-1:0] tileX;
    logic [TILE_IDX_W-1:0] tileY;
    logic [TILE_K_W-1:0]   k;
  } walkPos_t;

  function automatic hdrFields_t decodeHdr(input logic [31:0] h);
    hdrFields_t f;
    f.xTile32 = h[5:0];
    f.yTile32 = h[11:7];
    f.wExp    = h[16:14];
    f.hExp    = h[19:17];
    f.page    = h[20];
    f.byteSel = h[22:21];
    f.is16    = h[23];
    f.kind    = h[27:24];
    return f;
  endfunction

  function automatic logic kindKnown(input logic [3:0] kind);
    return (kind == KIND_FULL) || (kind == KIND_BASE) || (kind == KIND_MIPS);
  endfunction

  function automatic logic [LVL_W-1:0] lastLevel(input hdrFields_t f);
    logic [2:0] minExp;
    minExp = (f.wExp < f.hExp) ? f.wExp : f.hExp;
    if (f.kind == KIND_BASE) return '0;
    return LVL_W'(minExp) + LVL_W'(2);
  endfunction
endpackage

// File: rtl/texupl_ctrl.sv
module texupl_ctrl
  import texupl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [31:0] header,
  input  hdrFields_t  curHdr,
  input  logic        inValid,
  input  logic        slotFree,
  input  logic        wrValid,
  output logic        inReady,
  output ctrlStrobe_t strobe,
  output walkPos_t    pos,
  output logic        done
);
  localparam int TW = TILE_IDX_W;
  localparam logic [TW:0] ONE = (TW+1)'(1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} state_t;
  state_t state;

  hdrFields_t newHdr;
  logic [LVL_W-1:0] lvlEnd, shX, shY;
  logic [TW-1:0] maxX, maxY;
  logic half, tileLast, rowLast, levelLast, walkLast;

  assign newHdr = decodeHdr(header);

  always_comb begin
    lvlEnd    = lastLevel(curHdr);
    shX       = LVL_W'(2) + LVL_W'(curHdr.wExp) - pos.level;
    shY       = LVL_W'(2) + LVL_W'(curHdr.hExp) - pos.level;
    maxX      = TW'((ONE << shX) - ONE);
    maxY      = TW'((ONE << shY) - ONE);
    tileLast  = &pos.k;
    rowLast   = tileLast && (pos.tileX == maxX);
    levelLast = rowLast && (pos.tileY == maxY);
    walkLast  = levelLast && (pos.level == lvlEnd);
    half      = !curHdr.is16 && pos.k[0];
    inReady   = (state == ST_RUN) && slotFree && !half;
    strobe.latchHdr = (state == ST_IDLE) && start;
    strobe.takeWord = inValid && inReady;
    strobe.fromHold = half;
    strobe.emit     = (state == ST_RUN) && (half ? slotFree : strobe.takeWord);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      pos   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            pos       <= '0;
            pos.level <= (newHdr.kind == KIND_MIPS) ? LVL_W'(1) : LVL_W'(0);
            state     <= kindKnown(newHdr.kind) ? ST_RUN : ST_DRAIN;
          end
        end
        ST_RUN: begin
          if (strobe.emit) begin
            if (walkLast) state <= ST_DRAIN;
            pos.k <= pos.k + 1'b1;
            if (tileLast) begin
              if (pos.tileX == maxX) begin
                pos.tileX <= '0;
                if (pos.tileY == maxY) begin
                  pos.tileY <= '0;
                  pos.level <= pos.level + 1'b1;
                end else begin
                  pos.tileY <= pos.tileY + 1'b1;
                end
              end else begin
                pos.tileX <= pos.tileX + 1'b1;
              end
            end
          end
        end
        default: begin
          if (slotFree) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R11
  AST_DONE_SLOT_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !wrValid); // R11
endmodule

// File: rtl/texupl_dp.sv
module texupl_dp
  import texupl_pkg::*;
#(
  parameter int SHEET_LOG2 = 11
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [31:0]             header,
  input  logic [TEXEL_W-1:0]      inData,
  input  ctrlStrobe_t             strobe,
  input  walkPos_t                pos,
  input  logic                    wrReady,
  output hdrFields_t              curHdr,
  output logic                    slotFree,
  output logic                    wrValid,
  output logic [2*SHEET_LOG2-1:0] wrAddr,
  output logic [TEXEL_W-1:0]      wrData,
  output logic [1:0]              wrBe
);
  localparam int CW = SHEET_LOG2;
  localparam logic [CW:0] SIDE      = (CW+1)'(1) << CW;
  localparam logic [CW:0] HALF_SIDE = SIDE >> 1;

  logic [31:0] hdrReg;
  logic [7:0]  holdByte;
  logic [CW-1:0] xOrig, yOrig, levelX, levelY, col, row;
  logic [CW:0] xBaseW, yBaseW;
  logic [2:0] subR, subC;
  logic [7:0] curByte;
  logic [TEXEL_W-1:0] nextData;
  logic [1:0] nextBe;

  assign curHdr   = decodeHdr(hdrReg);
  assign slotFree = !wrValid || wrReady;

  always_comb begin
    xOrig  = CW'({curHdr.xTile32, 5'b00000});
    yOrig  = CW'({curHdr.yTile32, 5'b00000});
    xBaseW = SIDE - (SIDE >> pos.level);
    yBaseW = HALF_SIDE - (HALF_SIDE >> pos.level);
    levelX = xBaseW[CW-1:0] + (xOrig >> pos.level);
    levelY = yBaseW[CW-1:0] + (yOrig >> pos.level)
           + (curHdr.page ? HALF_SIDE[CW-1:0] : '0);
    if (curHdr.is16) begin
      subR = {pos.k[5], pos.k[4], pos.k[1]};
      subC = {pos.k[3], pos.k[2], ~pos.k[0]};
    end else begin
      subR = {pos.k[5], pos.k[4], ~pos.k[1]};
      subC = {pos.k[3], pos.k[2], pos.k[0]};
    end
    col = levelX + CW'({pos.tileX, 3'b000}) + CW'(subC);
    row = levelY + CW'({pos.tileY, 3'b000}) + CW'(subR);
    curByte = strobe.fromHold ? holdByte : inData[15:8];
    if (curHdr.is16) begin
      nextData = inData;
      nextBe   = 2'b11;
    end else begin
      nextData = {curByte, curByte};
      nextBe   = curHdr.byteSel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrReg   <= '0;
      holdByte <= '0;
      wrValid  <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
      wrBe     <= '0;
    end else begin
      if (strobe.latchHdr) hdrReg <= header;
      if (strobe.takeWord) holdByte <= inData[7:0];
      if (strobe.emit) begin
        wrValid <= 1'b1;
        wrAddr  <= {row, col};
        wrData  <= nextData;
        wrBe    <= nextBe;
      end else if (wrReady) begin
        wrValid <= 1'b0;
      end
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> (wrValid && $stable(wrAddr) && $stable(wrData) && $stable(wrBe))); // R10
endmodule

// File: rtl/tex_upload_addrgen.sv
module tex_upload_addrgen
  import texupl_pkg::*;
#(
  parameter int SHEET_LOG2 = 11
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [31:0]             header,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic [TEXEL_W-1:0]      inData,
  output logic                    wrValid,
  input  logic                    wrReady,
  output logic [2*SHEET_LOG2-1:0] wrAddr,
  output logic [TEXEL_W-1:0]      wrData,
  output logic [1:0]              wrBe,
  output logic                    done
);
  hdrFields_t  curHdr;
  ctrlStrobe_t strobe;
  walkPos_t    pos;
  logic        slotFree;

  texupl_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .header(header), .curHdr(curHdr),
    .inValid(inValid), .slotFree(slotFree), .wrValid(wrValid),
    .inReady(inReady), .strobe(strobe), .pos(pos), .done(done)
  );

  texupl_dp #(.SHEET_LOG2(SHEET_LOG2)) u_dp (
    .clk(clk), .rstN(rstN), .header(header), .inData(inData), .strobe(strobe),
    .pos(pos), .wrReady(wrReady), .curHdr(curHdr), .slotFree(slotFree),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData), .wrBe(wrBe)
  );

  AST_NO_TAKE_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |-> !inReady); // R10
endmodule

// File: tb/tb_tex_upload_addrgen.sv
module tb_tex_upload_addrgen;
  localparam int SL = 11;
  localparam int SIDE = 1 << SL;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, start, inValid, inReady, wrValid, wrReady, done;
  logic [31:0] header;
  logic [15:0] inData, wrData;
  logic [2*SL-1:0] wrAddr;
  logic [1:0] wrBe;

  int errors = 0;
  int checks = 0;

  tex_upload_addrgen #(.SHEET_LOG2(SL)) dut (
    .clk(clk), .rstN(rstN), .start(start), .header(header), .inValid(inValid),
    .inReady(inReady), .inData(inData), .wrValid(wrValid), .wrReady(wrReady),
    .wrAddr(wrAddr), .wrData(wrData), .wrBe(wrBe), .done(done)
  );

  task automatic check(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  function automatic int decodeTab(input int i);
    return ((i >> 4) * 16) + (((i >> 3) & 1) * 2) + (((i & 7) >> 1) * 4) + (i & 1);
  endfunction

  function automatic int firstLvl(input logic [31:0] h);
    return (h[27:24] == 4'd2) ? 1 : 0;
  endfunction

  function automatic int lastLvl(input logic [31:0] h);
    int w = 32 << h[16:14];
    int ht = 32 << h[19:17];
    int n = 0;
    if (h[27:24] == 4'd1) return 0;
    while (w > 8 && ht > 8) begin
      w = w / 2;
      ht = ht / 2;
      n++;
    end
    return n;
  endfunction

  function automatic int totalWrites(input logic [31:0] h);
    int w = 32 << h[16:14];
    int ht = 32 << h[19:17];
    int sum = 0;
    if (h[27:24] > 4'd2) return 0;
    for (int L = firstLvl(h); L <= lastLvl(h); L++)
      sum += ((w >> L) / 8) * ((ht >> L) / 8) * 64;
    return sum;
  endfunction

  function automatic int expAddr(input logic [31:0] h, input int j);
    int bx = 32 * int'(h[5:0]);
    int by = 32 * int'(h[11:7]);
    int w = 32 << h[16:14];
    int ht = 32 << h[19:17];
    int rem = j;
    for (int L = firstLvl(h); L <= lastLvl(h); L++) begin
      int tx = (w >> L) / 8;
      int ty = (ht >> L) / 8;
      int n = tx * ty * 64;
      if (rem < n) begin
        int tile = rem / 64;
        int k = rem % 64;
        int xb = 0;
        int yb = 0;
        int r = 0;
        int c = 0;
        for (int m = 0; m < L; m++) begin
          xb += 1024 >> m;
          yb += 512 >> m;
        end
        xb += bx >> L;
        yb += (by >> L) + (h[20] ? 1024 : 0);
        if (h[23]) begin
          for (int d = 0; d < 64; d++)
            if (decodeTab(d ^ 1) == k) begin r = d / 8; c = d % 8; end
        end else begin
          for (int yy = 0; yy < 8; yy++)
            for (int xx = 0; xx < 8; xx += 2)
              if (decodeTab(((yy ^ 1) * 8) + (xx ^ 1)) / 2 == k / 2) begin
                r = yy;
                c = xx + (k % 2);
              end
        end
        return ((yb + (tile / tx) * 8 + r) % SIDE) * SIDE + ((xb + (tile % tx) * 8 + c) % SIDE);
      end
      rem -= n;
    end
    return -1;
  endfunction

  function automatic logic [15:0] wordOf(input int idx, input int salt);
    return 16'(idx * 40503 + salt);
  endfunction

  task automatic runUpload(input logic [31:0] h, input string tag, input int readyPct,
                           input int validPct, input bit midStart);
    int total = totalWrites(h);
    int nWords = h[23] ? total : total / 2;
    int inIdx = 0;
    int outIdx = 0;
    int lastHs = -1;
    int sample = 0;
    int salt = int'($urandom_range(65535));
    bit finished = 0;
    bit prevStall = 0;
    logic [2*SL-1:0] pAddr = '0;
    logic [15:0] pData = '0;
    logic [1:0] pBe = '0;
    while (!finished) begin
      @(negedge clk);
      start   = (sample == 0) || (midStart && sample == 12);
      header  = (sample == 0) ? h : 32'h0100_0000;
      inValid = (inIdx < nWords) && (int'($urandom_range(99)) < validPct);
      inData  = wordOf(inIdx, salt);
      wrReady = int'($urandom_range(99)) < readyPct;
      #1;
      if (prevStall)
        check(wrValid && wrAddr == pAddr && wrData == pData && wrBe == pBe, "R10",
              $sformatf("held write changed: actual addr=%0h data=%0h be=%0h expected addr=%0h data=%0h be=%0h",
                        wrAddr, wrData, wrBe, pAddr, pData, pBe));
      if (wrValid && !wrReady)
        check(!inReady, "R10", $sformatf("inReady actual=%0b expected=0 while stalled", inReady));
      prevStall = wrValid && !wrReady;
      pAddr = wrAddr; pData = wrData; pBe = wrBe;
      if (inValid && inReady) inIdx++;
      if (done) begin
        if (total > 0)
          check(outIdx == total && sample == lastHs + 1, "R11",
                $sformatf("%s done: actual writes=%0d at sample %0d expected writes=%0d at sample %0d",
                          tag, outIdx, sample, total, lastHs + 1));
        else
          check(outIdx == 0 && sample == 2, "R8",
                $sformatf("%s ignored kind: actual writes=%0d done sample=%0d expected 0 and 2",
                          tag, outIdx, sample));
        finished = 1;
      end
      if (wrValid && wrReady) begin
        if (outIdx >= total) begin
          check(0, tag, $sformatf("extra write actual index=%0d expected total=%0d", outIdx, total));
        end else begin
          logic [15:0] w;
          logic [7:0] b;
          int ea;
          logic [15:0] ed;
          logic [1:0] eb;
          w  = wordOf(h[23] ? outIdx : outIdx / 2, salt);
          b  = (outIdx % 2 == 1) ? w[7:0] : w[15:8];
          ea = expAddr(h, outIdx);
          ed = h[23] ? w : {b, b};
          eb = h[23] ? 2'b11 : h[22:21];
          check(int'(wrAddr) == ea && wrData == ed && wrBe == eb, tag,
                $sformatf("write %0d actual addr=%0h data=%0h be=%0h expected addr=%0h data=%0h be=%0h",
                          outIdx, wrAddr, wrData, wrBe, ea, ed, eb));
        end
        outIdx++;
        lastHs = sample;
      end
      sample++;
      if (sample > 40000 && !finished) begin
        check(0, tag, $sformatf("upload timeout actual writes=%0d expected %0d", outIdx, total));
        finished = 1;
      end
    end
    start = 0; inValid = 0; wrReady = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1;
      check(!done && !wrValid, "R11",
            $sformatf("after done actual done=%0b wrValid=%0b expected 0 0", done, wrValid));
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual run still going expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 0; start = 0; header = '0; inValid = 0; inData = '0; wrReady = 1;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R1 reset state
    check(!wrValid && !done && !inReady, "R1",
          $sformatf("reset actual wrValid=%0b done=%0b inReady=%0b expected 0 0 0", wrValid, done, inReady));

    // 16-bit base only, 32x32 at column 32, row 64
    runUpload(32'h0180_0101, "R2 R3 R5 R6", 100, 100, 0);
    // 8-bit base only, 64x32, low byte target, with stalls
    runUpload(32'h0120_4000 | (32'd5 << 7) | 32'd2, "R4 R5 R7", 60, 70, 0);
    // 8-bit base only, high byte target, page 1, column wraps past 2047
    runUpload(32'h0150_403F, "R2 R4 R7", 75, 80, 0);
    // 16-bit base plus reduced levels, 64x32 on page 1
    runUpload(32'h0090_4183, "R8 R9 R3", 70, 80, 0);
    // 8-bit reduced levels only, 32x64, both bytes enabled
    runUpload(32'h0262_0000 | (32'd7 << 7) | 32'd9, "R8 R9 R4", 80, 80, 0);
    // unknown level selection
    runUpload(32'h0380_0000, "R8", 100, 100, 0);
    // start pulse while busy
    runUpload(32'h0180_0000 | (32'd3 << 7) | 32'd10, "R12 R10", 50, 90, 0);
    runUpload(32'h0180_0000 | (32'd3 << 7) | 32'd10, "R12", 50, 90, 1);

    for (int n = 0; n < 10; n++) begin
      logic [31:0] h;
      h = $urandom;
      h[31:28] = 4'h0;
      h[27:24] = 4'($urandom_range(2));
      h[19:17] = 3'($urandom_range(1));
      h[16:14] = 3'($urandom_range(1));
      runUpload(h, "R3 R4 R5 R6 R7 R9 R10", 80, 85, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule